// File: doc/BRIEF.md
# I2C Bus Transaction Monitor

This block is a receive-only observer attached to the two wires of an I2C bus. It samples the clock and data lines on a much faster system clock and never drives either wire. Each line passes through a two-flop synchronizer and a stability filter that rejects short glitches. From the filtered levels the block finds bus conditions and clock edges, and builds each 9-bit frame.

For every bus occurrence the block issues one event record together with a single-cycle strobe. There is no backpressure. An occurrence is a start, a repeated start, a stop, an address frame or a data frame. A record holds a command code, a decoded byte, a negative-acknowledge flag and the raw eight bits of the frame. The first frame after any start is an address frame. Its lowest bit sets the transfer direction, and the block applies that direction to the data frames that follow until the next start or stop.

The monitor suits protocol debug logic, trace capture and traffic counters that must watch a shared bus without loading it.

Top module: `i2c_txn_monitor`

## Requirements
- R1: After reset `evt_valid` is low, and an idle bus (both lines held high) produces no event.
- R2: A fall of the filtered data line while the filtered clock line is high, outside a transaction, produces an event with command code 0 (start) whose byte, raw and nack fields are all zero.
- R3: A rise of the filtered data line while the filtered clock line is high produces command code 6 (stop) with zero byte, raw and nack fields. The block returns to idle, so the next start is reported as code 0 again.
- R4: After a start, nine clock rising edges form an address frame: eight bits sampled most-significant first, then the acknowledge bit. The event has code 3 (address write) when the eighth bit is 0, or code 2 (address read) when it is 1. Its byte field is the upper seven bits, zero-extended, and its raw field is all eight bits.
- R5: The acknowledge bit sampled on the ninth clock rise is reported in `evt_nack`: 0 when the line was low and 1 when it was high.
- R6: Every later nine-bit frame is a data frame, with byte equal to raw. It has code 5 (data write) or 4 (data read) according to the direction bit of the most recent address frame, and any number of data frames may follow one another.
- R7: A start that occurs after an earlier start with no stop between them is reported as code 1 (repeated start), and the frame that follows it is treated as a new address frame.
- R8: A start or stop seen while a frame is only partly collected discards that frame without a byte event. Bit collection restarts from zero at the next start.
- R9: A data-line pulse shorter than `FILT_CYCLES` system clocks is ignored, and no event results from it.
- R10: `evt_valid` is high only when an event is issued, and each event is issued in exactly one cycle.
- R11: Changes on the data line while the clock line is low produce no event, and they do not disturb the frame being collected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| evt_valid | output | 1 | Single-cycle strobe marking a new event record |
| evt_cmd | output | 3 | Command code: 0 start, 1 repeated start, 2 address read, 3 address write, 4 data read, 5 data write, 6 stop |
| evt_byte | output | 8 | Seven-bit address (zero-extended) or data byte, zero for start and stop |
| evt_nack | output | 1 | Acknowledge bit of the frame, 1 means not acknowledged |
| evt_raw | output | 8 | Eight frame bits as received, without the acknowledge bit |

## Verification
The bench builds the monitor with `FILT_CYCLES` set to 3, below the default. A one-cycle data glitch can then be placed with the clock line high and shown to stay below the filter threshold. Every bus phase is held for eight system clocks, which exceeds the filter window and the register pipeline. This lets the bench place clock edges in the middle of a partly collected frame, so aborts by start and by stop can be tested. It also exposes data-line toggles that happen while the clock line is low.

// File: rtl/i2c_mon_pkg.sv
// Package: i2c_mon_pkg
// Shared sizes, command codes and state encoding for the I2C bus monitor.
// Assumes byte-wide frames followed by one acknowledge bit.
package i2c_mon_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int CMD_W      = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_START     = 3'd0,
        CMD_RESTART   = 3'd1,
        CMD_ADDR_RD   = 3'd2,
        CMD_ADDR_WR   = 3'd3,
        CMD_DATA_RD   = 3'd4,
        CMD_DATA_WR   = 3'd5,
        CMD_STOP      = 3'd6
    } mon_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } mon_state_e;

endpackage

// File: rtl/i2c_mon_line_filter.sv
// Module: i2c_mon_line_filter
// Brings one asynchronous bus line into the clock domain with two flops, then
// lets the output follow only after the synchronized level has held steady for
// FILT_CYCLES consecutive clocks. Assumes the bus idles high, so reset sets the
// output high.
module i2c_mon_line_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int FC_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

    logic            sync1_q;
    logic            sync2_q;
    logic [FC_W-1:0] stable_cnt_q;

    // Two-stage synchronizer against metastability.
    always_ff @(posedge clk) begin : p_sync
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= line_i;
            sync2_q <= sync1_q;
        end
    end

    // Accept a new level only after it has been seen for FILT_CYCLES clocks.
    always_ff @(posedge clk) begin : p_filter
        if (!rst_n) begin
            line_o       <= 1'b1;
            stable_cnt_q <= '0;
        end else if (sync2_q != line_o) begin
            if (stable_cnt_q == FC_W'(FILT_CYCLES - 1)) begin
                line_o       <= sync2_q;
                stable_cnt_q <= '0;
            end else begin
                stable_cnt_q <= stable_cnt_q + 1'b1;
            end
        end else begin
            stable_cnt_q <= '0;
        end
    end

endmodule

// File: rtl/i2c_mon_cond_detect.sv
// Module: i2c_mon_cond_detect
// Keeps the previous filtered levels of both lines and produces one-cycle
// pulses for a start, a stop and a clock rising edge. Assumes both inputs are
// already synchronous and glitch-free.
module i2c_mon_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic sda_d
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Remember the previous levels to form the edge comparisons.
    always_ff @(posedge clk) begin : p_history
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    // Register the condition pulses together with the sampled data level.
    always_ff @(posedge clk) begin : p_pulses
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            rise_p  <= 1'b0;
            sda_d   <= 1'b1;
        end else begin
            start_p <= scl_f &  sda_prev_q & ~sda_f;
            stop_p  <= scl_f & ~sda_prev_q &  sda_f;
            rise_p  <= ~scl_prev_q & scl_f;
            sda_d   <= sda_f;
        end
    end

endmodule

// File: rtl/i2c_mon_frame_fsm.sv
// Module: i2c_mon_frame_fsm
// Three-state transaction tracker. It shifts in frame bits on clock rises,
// classifies each completed frame as address or data and as read or write,
// tells a first start from a repeated one, and drives the registered event
// record. Assumes at most one condition pulse per cycle has meaning: a start or
// stop takes priority over a clock rise.
module i2c_mon_frame_fsm
    import i2c_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              rise_p,
    input  logic              sda_d,
    output logic              evt_valid,
    output logic [CMD_W-1:0]  evt_cmd,
    output logic [BYTE_W-1:0] evt_byte,
    output logic              evt_nack,
    output logic [BYTE_W-1:0] evt_raw
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    mon_state_e        state_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              repeat_q;
    logic              dir_rd_q;

    // Transaction state, frame assembly and event record generation.
    always_ff @(posedge clk) begin : p_track
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            repeat_q  <= 1'b0;
            dir_rd_q  <= 1'b0;
            evt_valid <= 1'b0;
            evt_cmd   <= CMD_START;
            evt_byte  <= '0;
            evt_nack  <= 1'b0;
            evt_raw   <= '0;
        end else begin
            evt_valid <= 1'b0;
            if (start_p) begin
                evt_valid <= 1'b1;
                evt_cmd   <= repeat_q ? CMD_RESTART : CMD_START;
                evt_byte  <= '0;
                evt_nack  <= 1'b0;
                evt_raw   <= '0;
                state_q   <= ST_ADDR;
                shreg_q   <= '0;
                bit_cnt_q <= '0;
                repeat_q  <= 1'b1;
                dir_rd_q  <= 1'b0;
            end else if (stop_p && state_q != ST_IDLE) begin
                evt_valid <= 1'b1;
                evt_cmd   <= CMD_STOP;
                evt_byte  <= '0;
                evt_nack  <= 1'b0;
                evt_raw   <= '0;
                state_q   <= ST_IDLE;
                shreg_q   <= '0;
                bit_cnt_q <= '0;
                repeat_q  <= 1'b0;
                dir_rd_q  <= 1'b0;
            end else if (rise_p && state_q != ST_IDLE) begin
                if (bit_cnt_q == LAST_BIT) begin
                    evt_valid <= 1'b1;
                    evt_nack  <= sda_d;
                    evt_raw   <= shreg_q;
                    if (state_q == ST_ADDR) begin
                        evt_cmd  <= shreg_q[0] ? CMD_ADDR_RD : CMD_ADDR_WR;
                        evt_byte <= {1'b0, shreg_q[BYTE_W-1:1]};
                        dir_rd_q <= shreg_q[0];
                    end else begin
                        evt_cmd  <= dir_rd_q ? CMD_DATA_RD : CMD_DATA_WR;
                        evt_byte <= shreg_q;
                    end
                    state_q   <= ST_DATA;
                    shreg_q   <= '0;
                    bit_cnt_q <= '0;
                end else begin
                    shreg_q   <= {shreg_q[BYTE_W-2:0], sda_d};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_txn_monitor.sv
// Module: i2c_txn_monitor
// Top of the passive I2C bus monitor. It filters both bus lines, detects
// conditions and clock edges, and tracks frames to produce one event record
// per bus occurrence. It never drives the bus. Assumes the system clock runs
// well above the bus clock, so that every bus phase outlasts FILT_CYCLES plus
// the synchronizer depth.
module i2c_txn_monitor
    import i2c_mon_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              evt_valid,
    output logic [CMD_W-1:0]  evt_cmd,
    output logic [BYTE_W-1:0] evt_byte,
    output logic              evt_nack,
    output logic [BYTE_W-1:0] evt_raw
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_filt;
    logic               scl_filt;
    logic               sda_filt;
    logic               start_p;
    logic               stop_p;
    logic               rise_p;
    logic               sda_d;

    assign line_raw = {sda_i, scl_i};
    assign scl_filt = line_filt[0];
    assign sda_filt = line_filt[1];

    // One synchronizer and glitch filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_mon_line_filter #(
            .FILT_CYCLES (FILT_CYCLES)
        ) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[g]),
            .line_o (line_filt[g])
        );
    end

    i2c_mon_cond_detect i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_filt),
        .sda_f   (sda_filt),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .sda_d   (sda_d)
    );

    i2c_mon_frame_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .rise_p    (rise_p),
        .sda_d     (sda_d),
        .evt_valid (evt_valid),
        .evt_cmd   (evt_cmd),
        .evt_byte  (evt_byte),
        .evt_nack  (evt_nack),
        .evt_raw   (evt_raw)
    );

endmodule

// File: rtl/i2c_txn_monitor_checker.sv
// Module: i2c_txn_monitor_checker
// Protocol checker bound to the monitor top. It follows the event stream on
// its own and checks field rules, start/repeated-start ordering and the
// consistency of the data direction. Assumes the bind gives it the filtered
// clock line.
module i2c_txn_monitor_checker
    import i2c_mon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_filt,
    input logic              evt_valid,
    input logic [CMD_W-1:0]  evt_cmd,
    input logic [BYTE_W-1:0] evt_byte,
    input logic              evt_nack,
    input logic [BYTE_W-1:0] evt_raw
);

    logic in_txn_q;
    logic addr_seen_q;
    logic dir_rd_q;

    // Track the transaction from the event stream alone.
    always_ff @(posedge clk) begin : p_model
        if (!rst_n) begin
            in_txn_q    <= 1'b0;
            addr_seen_q <= 1'b0;
            dir_rd_q    <= 1'b0;
        end else if (evt_valid) begin
            case (evt_cmd)
                CMD_START, CMD_RESTART: begin
                    in_txn_q    <= 1'b1;
                    addr_seen_q <= 1'b0;
                end
                CMD_STOP: begin
                    in_txn_q    <= 1'b0;
                    addr_seen_q <= 1'b0;
                end
                CMD_ADDR_RD: begin
                    addr_seen_q <= 1'b1;
                    dir_rd_q    <= 1'b1;
                end
                CMD_ADDR_WR: begin
                    addr_seen_q <= 1'b1;
                    dir_rd_q    <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2/R3: condition events carry no byte, raw or acknowledge content.
    p_cond_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && (evt_cmd == CMD_START || evt_cmd == CMD_RESTART || evt_cmd == CMD_STOP)
        |-> (evt_byte == '0) && (evt_raw == '0) && !evt_nack);

    // R2: a first start only outside a transaction.
    p_first_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_cmd == CMD_START |-> !in_txn_q);

    // R7: a repeated start only inside a transaction.
    p_repeat_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_cmd == CMD_RESTART |-> in_txn_q);

    // R4: the address byte is the raw frame without its direction bit.
    p_addr_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && (evt_cmd == CMD_ADDR_RD || evt_cmd == CMD_ADDR_WR)
        |-> (evt_byte[BYTE_W-1] == 1'b0) && (evt_raw[0] == (evt_cmd == CMD_ADDR_RD))
            && in_txn_q && !addr_seen_q);

    // R6: data frames follow an address frame and inherit its direction.
    p_data_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && (evt_cmd == CMD_DATA_RD || evt_cmd == CMD_DATA_WR)
        |-> addr_seen_q && (dir_rd_q == (evt_cmd == CMD_DATA_RD)) && (evt_byte == evt_raw));

    // R11: every event is tied to a moment when the filtered clock line is high.
    p_event_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> scl_filt);

    // R10: only defined command codes are issued.
    p_cmd_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_cmd <= CMD_STOP);

endmodule

bind i2c_txn_monitor i2c_txn_monitor_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_filt  (scl_filt),
    .evt_valid (evt_valid),
    .evt_cmd   (evt_cmd),
    .evt_byte  (evt_byte),
    .evt_nack  (evt_nack),
    .evt_raw   (evt_raw)
);

// File: tb/test_i2c_txn_monitor.sv
// Directed bench for the I2C bus monitor: one task per scenario, each task
// checking the events it caused.
module test_i2c_txn_monitor;

    localparam int HOLD   = 8;
    localparam int MAXEVT = 64;

    logic       clk;
    logic       rst_n;
    logic       scl;
    logic       sda;
    logic       evt_valid;
    logic [2:0] evt_cmd;
    logic [7:0] evt_byte;
    logic       evt_nack;
    logic [7:0] evt_raw;

    int checks;
    int errors;
    int n_evt;
    int valid_run;

    logic [2:0] rec_cmd  [MAXEVT];
    logic [7:0] rec_byte [MAXEVT];
    logic       rec_nack [MAXEVT];
    logic [7:0] rec_raw  [MAXEVT];

    i2c_txn_monitor #(
        .FILT_CYCLES (3)
    ) i_i2c_txn_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda),
        .evt_valid (evt_valid),
        .evt_cmd   (evt_cmd),
        .evt_byte  (evt_byte),
        .evt_nack  (evt_nack),
        .evt_raw   (evt_raw)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Record every event away from the active edge.
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            if (n_evt < MAXEVT) begin
                rec_cmd[n_evt]  = evt_cmd;
                rec_byte[n_evt] = evt_byte;
                rec_nack[n_evt] = evt_nack;
                rec_raw[n_evt]  = evt_raw;
            end
            n_evt = n_evt + 1;
            valid_run = valid_run + 1;
        end else begin
            valid_run = 0;
        end
        if (valid_run > 1) begin
            errors = errors + 1;
            $display("FAIL R10: valid held %0d cycles, expected 1", valid_run);
        end
    end

    task automatic wait_phase();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda = b;
        wait_phase();
        scl = 1'b1;
        wait_phase();
        scl = 1'b0;
        wait_phase();
    endtask

    task automatic send_frame(input logic [7:0] b, input logic ack_hi);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ack_hi);
    endtask

    task automatic bus_start();
        sda = 1'b0;
        wait_phase();
        scl = 1'b0;
        wait_phase();
    endtask

    task automatic bus_restart();
        sda = 1'b1;
        wait_phase();
        scl = 1'b1;
        wait_phase();
        sda = 1'b0;
        wait_phase();
        scl = 1'b0;
        wait_phase();
    endtask

    task automatic bus_stop();
        sda = 1'b0;
        wait_phase();
        scl = 1'b1;
        wait_phase();
        sda = 1'b1;
        wait_phase();
        wait_phase();
    endtask

    task automatic clear_log();
        n_evt = 0;
    endtask

    task automatic expect_count(input int n, input string tag);
        checks = checks + 1;
        if (n_evt != n) begin
            errors = errors + 1;
            $display("FAIL %s: event count got %0d expected %0d", tag, n_evt, n);
        end
    endtask

    task automatic expect_evt(input int i, input logic [2:0] c, input logic [7:0] b,
                              input logic k, input logic [7:0] r, input string tag);
        checks = checks + 1;
        if (i >= n_evt || rec_cmd[i] !== c || rec_byte[i] !== b ||
            rec_nack[i] !== k || rec_raw[i] !== r) begin
            errors = errors + 1;
            if (i >= n_evt)
                $display("FAIL %s: event %0d missing, expected cmd=%0d byte=%02h nack=%0b raw=%02h",
                         tag, i, c, b, k, r);
            else
                $display("FAIL %s: event %0d got cmd=%0d byte=%02h nack=%0b raw=%02h expected cmd=%0d byte=%02h nack=%0b raw=%02h",
                         tag, i, rec_cmd[i], rec_byte[i], rec_nack[i], rec_raw[i], c, b, k, r);
        end
    endtask

    // R1: quiet after reset and on an idle bus.
    task automatic t_reset_idle();
        clear_log();
        checks = checks + 1;
        if (evt_valid !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1: evt_valid got %0b expected 0", evt_valid);
        end
        repeat (40) @(negedge clk);
        expect_count(0, "R1");
    endtask

    // R2 R3 R4 R5 R6: write transaction with two data bytes.
    task automatic t_write_txn();
        clear_log();
        bus_start();
        send_frame(8'hA4, 1'b0);
        send_frame(8'h3C, 1'b0);
        send_frame(8'hF0, 1'b1);
        bus_stop();
        expect_count(5, "R6");
        expect_evt(0, 3'd0, 8'h00, 1'b0, 8'h00, "R2");
        expect_evt(1, 3'd3, 8'h52, 1'b0, 8'hA4, "R4");
        expect_evt(2, 3'd5, 8'h3C, 1'b0, 8'h3C, "R6");
        expect_evt(3, 3'd5, 8'hF0, 1'b1, 8'hF0, "R5");
        expect_evt(4, 3'd6, 8'h00, 1'b0, 8'h00, "R3");
    endtask

    // R7 R4 R6: write then repeated start and read.
    task automatic t_repeated_read();
        clear_log();
        bus_start();
        send_frame(8'hA4, 1'b0);
        send_frame(8'h01, 1'b0);
        bus_restart();
        send_frame(8'hA5, 1'b0);
        send_frame(8'h99, 1'b1);
        bus_stop();
        expect_count(7, "R7");
        expect_evt(0, 3'd0, 8'h00, 1'b0, 8'h00, "R2");
        expect_evt(2, 3'd5, 8'h01, 1'b0, 8'h01, "R6");
        expect_evt(3, 3'd1, 8'h00, 1'b0, 8'h00, "R7");
        expect_evt(4, 3'd2, 8'h52, 1'b0, 8'hA5, "R4");
        expect_evt(5, 3'd4, 8'h99, 1'b1, 8'h99, "R6");
        expect_evt(6, 3'd6, 8'h00, 1'b0, 8'h00, "R3");
    endtask

    // R3: after a stop the next start is a first start again.
    task automatic t_stop_resets_repeat();
        clear_log();
        bus_start();
        bus_stop();
        bus_start();
        bus_stop();
        expect_count(4, "R3");
        expect_evt(1, 3'd6, 8'h00, 1'b0, 8'h00, "R3");
        expect_evt(2, 3'd0, 8'h00, 1'b0, 8'h00, "R3");
    endtask

    // R8: partial address frame aborted by a repeated start, then by a stop.
    task automatic t_abort();
        clear_log();
        bus_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        bus_restart();
        send_frame(8'h90, 1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        bus_stop();
        expect_count(4, "R8");
        expect_evt(1, 3'd1, 8'h00, 1'b0, 8'h00, "R8");
        expect_evt(2, 3'd3, 8'h48, 1'b0, 8'h90, "R8");
        expect_evt(3, 3'd6, 8'h00, 1'b0, 8'h00, "R8");
    endtask

    // R9: a one-cycle data glitch with the clock line high is ignored.
    task automatic t_glitch();
        clear_log();
        @(negedge clk);
        sda = 1'b0;
        @(negedge clk);
        sda = 1'b1;
        repeat (30) @(negedge clk);
        expect_count(0, "R9");
        sda = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sda = 1'b1;
        repeat (30) @(negedge clk);
        expect_count(0, "R9");
    endtask

    // R11: data toggles while the clock is low add no event and keep the frame.
    task automatic t_sda_while_low();
        clear_log();
        bus_start();
        send_frame(8'h20, 1'b0);
        for (int i = 0; i < 4; i++) begin
            sda = ~sda;
            wait_phase();
        end
        expect_count(2, "R11");
        send_frame(8'h5A, 1'b0);
        bus_stop();
        expect_count(4, "R11");
        expect_evt(2, 3'd5, 8'h5A, 1'b0, 8'h5A, "R11");
    endtask

    initial begin
        checks    = 0;
        errors    = 0;
        n_evt     = 0;
        valid_run = 0;
        scl       = 1'b1;
        sda       = 1'b1;
        rst_n     = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_write_txn();
        t_repeated_read();
        t_stop_resets_repeat();
        t_abort();
        t_glitch();
        t_sda_while_low();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule